// File: doc/BRIEF.md
# Decode-Stage Branch Resolver and Next-PC Unit

This unit owns the fetch program counter of a five-stage pipeline. Conditional branches are settled while they sit in decode. The unit has its own zero detector and its own target adder, so a taken branch redirects fetch after one cycle. Without them the branch would wait for execute and memory, and the penalty would be three cycles. A branch tests one register value. It jumps when that value is zero, or when it is non-zero, depending on the opcode. No branch compares two registers.

The `DELAY_SLOT` parameter selects how the instruction fetched behind a taken branch is handled:

- **`DELAY_SLOT = 0` (predict not taken).** Fetch keeps running sequentially. When the branch resolves taken, the unit raises `flush`, and the fetch/decode latch must load a bubble with its write and memory enables cleared. In the following cycle the unit ignores the branch fields on its decode inputs, because that slot holds the bubble.
- **`DELAY_SLOT = 1` (delayed branch).** The instruction after the branch always runs, and the redirect takes effect behind it.

When the instruction directly ahead of a branch, now in execute, writes the register the branch reads, the unit holds the PC and raises `stall` for one cycle. It then evaluates the branch with the bypassed value.

Top module: `br_npc`

## Requirements
- R1: While `rst_n` is low, and right after reset, `pc` equals `RESET_PC` and both `flush` and `stall` are 0.
- R2: With no branch in decode, `pc` increases by 4 at every clock edge, and `flush` and `stall` stay 0.
- R3: A valid decode op 2'b01 (branch if zero) whose operand is zero is taken. At the next edge `pc` becomes `dec_pc4 + (sign-extended dec_off << 2)`.
- R4: A valid decode op 2'b10 (branch if non-zero) is taken when its operand is non-zero. It is not taken when its operand is zero.
- R5: A branch that is not taken loads `pc + 4` and raises neither `flush` nor `stall`.
- R6: `dec_off` is treated as a signed 16-bit word offset, so offsets with bit 15 set move the target backwards.
- R7: With `DELAY_SLOT` = 0, `flush` is 1 in the same cycle that a taken branch is in decode. In the cycle after a flush, the decode inputs are ignored: `pc` advances by 4 and `flush` stays 0.
- R8: With `DELAY_SLOT` = 1, `flush` is never raised. The taken branch still redirects at the next edge. A branch in the slot after it is evaluated normally.
- R9: A valid branch whose `dec_rs_idx` equals `ex_wr_idx` while `ex_wr_en` is 1 raises `stall` for exactly one cycle. During that cycle `pc` holds and `flush` is 0. In the next cycle the branch is resolved even if the match persists.
- R10: Ops 2'b00 and 2'b11, and any op while `dec_valid` is 0, are not branches. `pc` advances by 4 and no flush occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_op | input | 2 | Branch kind: 01 on zero, 10 on non-zero, else none |
| dec_rs_val | input | DW | Bypassed value of the tested register |
| dec_rs_idx | input | RW | Index of the tested register |
| dec_off | input | 16 | Signed word offset |
| dec_pc4 | input | AW | Address of the branch plus 4 |
| ex_wr_en | input | 1 | Instruction in execute writes a register |
| ex_wr_idx | input | RW | Register written by the instruction in execute |
| pc | output | AW | Fetch address |
| flush | output | 1 | Load a bubble into the fetch/decode latch |
| stall | output | 1 | Hold the PC and the fetch/decode latch |

## Verification
The unit keeps three pieces of state: the PC, a flag marking that decode holds a squashed bubble, and a flag marking that the one-cycle hazard stall has already been spent.

- **Wrong PC.** It shows on `pc` at the very next edge, as a wrong increment or a wrong target.
- **Wrong bubble flag.** It shows in the cycle after a taken branch. A stale branch there either redirects again or raises a second flush.
- **Wrong stall flag.** It shows one cycle after a hazard. The unit either stalls twice or never resolves the branch.

Each test therefore repeats the same decode inputs over two cycles and checks both cycles.

// File: rtl/br_npc.sv
module br_npc #(
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter int          RW         = 5,
  parameter bit          DELAY_SLOT = 1'b0,
  parameter logic [31:0] RESET_PC   = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic [1:0]    dec_op,
  input  logic [DW-1:0] dec_rs_val,
  input  logic [RW-1:0] dec_rs_idx,
  input  logic [15:0]   dec_off,
  input  logic [AW-1:0] dec_pc4,
  input  logic          ex_wr_en,
  input  logic [RW-1:0] ex_wr_idx,
  output logic [AW-1:0] pc,
  output logic          flush,
  output logic          stall
);
  localparam logic [1:0] OP_BZ  = 2'b01;
  localparam logic [1:0] OP_BNZ = 2'b10;
  localparam int         EXT_W  = AW - 18;

  logic [AW-1:0] pc_q;
  logic          bubble_q;
  logic          held_q;

  logic          is_br;
  logic          hazard;
  logic          rs_zero;
  logic          taken;
  logic [AW-1:0] target;
  logic [AW-1:0] pc_nxt;

  assign is_br   = dec_valid && !bubble_q && (dec_op == OP_BZ || dec_op == OP_BNZ);
  assign hazard  = is_br && ex_wr_en && (ex_wr_idx == dec_rs_idx) && !held_q;
  assign rs_zero = (dec_rs_val == '0);
  assign taken   = is_br && !hazard && ((dec_op == OP_BZ) ? rs_zero : !rs_zero);
  assign target  = dec_pc4 + {{EXT_W{dec_off[15]}}, dec_off, 2'b00};
  assign pc_nxt  = hazard ? pc_q : (taken ? target : pc_q + AW'(4));

  generate
    if (DELAY_SLOT) begin : g_delay
      assign flush = 1'b0;
    end else begin : g_squash
      assign flush = taken;
    end
  endgenerate

  assign stall = hazard;
  assign pc    = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC[AW-1:0];
      bubble_q <= 1'b0;
      held_q   <= 1'b0;
    end else begin
      pc_q     <= pc_nxt;
      bubble_q <= flush;
      held_q   <= hazard;
    end
  end
endmodule

module br_npc_chk #(
  parameter int AW         = 32,
  parameter bit DELAY_SLOT = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pc,
  input logic          flush,
  input logic          stall
);
  p_stall_holds_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (pc == $past(pc)));

  p_single_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  p_flush_not_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !stall);

  p_no_back_to_back_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  generate
    if (DELAY_SLOT) begin : g_ds
      p_slot_never_flushed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall || !flush);
    end
  endgenerate
endmodule

bind br_npc br_npc_chk #(.AW(AW), .DELAY_SLOT(DELAY_SLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .flush(flush), .stall(stall)
);

// File: tb/br_npc_bench.sv
module br_npc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [1:0]  dec_op = 2'b00;
  logic [31:0] dec_rs_val = '0;
  logic [4:0]  dec_rs_idx = '0;
  logic [15:0] dec_off = '0;
  logic [31:0] dec_pc4 = '0;
  logic        ex_wr_en = 1'b0;
  logic [4:0]  ex_wr_idx = '0;
  logic [31:0] pc, pc_ds;
  logic        flush, flush_ds, stall, stall_ds;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc;

  always #2 clk = ~clk;

  br_npc #(.DELAY_SLOT(1'b0)) u_br_npc (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op),
    .dec_rs_val(dec_rs_val), .dec_rs_idx(dec_rs_idx), .dec_off(dec_off),
    .dec_pc4(dec_pc4), .ex_wr_en(ex_wr_en), .ex_wr_idx(ex_wr_idx),
    .pc(pc), .flush(flush), .stall(stall));

  br_npc #(.DELAY_SLOT(1'b1)) u_br_npc_ds (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op),
    .dec_rs_val(dec_rs_val), .dec_rs_idx(dec_rs_idx), .dec_off(dec_off),
    .dec_pc4(dec_pc4), .ex_wr_en(ex_wr_en), .ex_wr_idx(ex_wr_idx),
    .pc(pc_ds), .flush(flush_ds), .stall(stall_ds));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    dec_valid = 1'b0; dec_op = 2'b00; dec_rs_val = '0; dec_rs_idx = '0;
    dec_off = '0; dec_pc4 = '0; ex_wr_en = 1'b0; ex_wr_idx = '0;
  endtask

  task automatic drive(input logic [1:0] op, input logic [31:0] rs, input logic [4:0] idx,
                       input logic [15:0] off, input logic [31:0] pc4);
    dec_valid = 1'b1; dec_op = op; dec_rs_val = rs; dec_rs_idx = idx;
    dec_off = off; dec_pc4 = pc4;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    cyc();
    check("R1 pc during reset", pc, 32'h100);
    cyc();
    rst_n = 1'b1;
    #1;
    check("R1 pc after reset", pc, 32'h100);
    check("R1 flush", {31'b0, flush}, 32'd0);
    check("R1 stall", {31'b0, stall}, 32'd0);
    check("R1 pc ds", pc_ds, 32'h100);
    exp_pc = 32'h100;
  endtask

  task automatic t_sequential();
    do_reset();
    for (int i = 0; i < 3; i++) begin
      cyc();
      exp_pc += 4;
      check("R2 sequential pc", pc, exp_pc);
      check("R2 no flush", {31'b0, flush}, 32'd0);
      check("R2 no stall", {31'b0, stall}, 32'd0);
    end
  endtask

  task automatic t_bz_taken_squash();
    do_reset();
    drive(2'b01, 32'd0, 5'd2, 16'h0010, 32'h200);
    #1;
    check("R7 flush on taken", {31'b0, flush}, 32'd1);
    cyc();
    check("R3 bz target", pc, 32'h240);
    #1;
    check("R7 stale branch ignored flush", {31'b0, flush}, 32'd0);
    cyc();
    check("R7 stale branch ignored pc", pc, 32'h244);
    idle();
  endtask

  task automatic t_bnz_and_not_taken();
    do_reset();
    drive(2'b10, 32'd5, 5'd1, 16'hFFFE, 32'h300);
    #1;
    check("R4 bnz taken flush", {31'b0, flush}, 32'd1);
    cyc();
    check("R6 R4 backward target", pc, 32'h2F8);
    idle();
    cyc();
    check("R2 pc after bubble", pc, 32'h2FC);
    drive(2'b01, 32'd7, 5'd1, 16'h0040, 32'h500);
    #1;
    check("R5 bz nonzero no flush", {31'b0, flush}, 32'd0);
    cyc();
    check("R5 bz nonzero pc+4", pc, 32'h300);
    drive(2'b10, 32'd0, 5'd1, 16'h0040, 32'h500);
    #1;
    check("R4 bnz zero no flush", {31'b0, flush}, 32'd0);
    cyc();
    check("R4 bnz zero pc+4", pc, 32'h304);
    idle();
  endtask

  task automatic t_far_negative();
    do_reset();
    drive(2'b01, 32'd0, 5'd9, 16'h8000, 32'h0004_0000);
    cyc();
    check("R6 most negative offset", pc, 32'h0002_0000);
    idle();
  endtask

  task automatic t_non_branch();
    do_reset();
    drive(2'b00, 32'd0, 5'd1, 16'h0100, 32'h800);
    #1;
    check("R10 op00 no flush", {31'b0, flush}, 32'd0);
    cyc();
    check("R10 op00 pc+4", pc, 32'h104);
    drive(2'b11, 32'd0, 5'd1, 16'h0100, 32'h800);
    cyc();
    check("R10 op11 pc+4", pc, 32'h108);
    drive(2'b01, 32'd0, 5'd1, 16'h0100, 32'h800);
    dec_valid = 1'b0;
    #1;
    check("R10 invalid no flush", {31'b0, flush}, 32'd0);
    cyc();
    check("R10 invalid pc+4", pc, 32'h10C);
    idle();
  endtask

  task automatic t_hazard();
    do_reset();
    drive(2'b01, 32'd0, 5'd3, 16'h0020, 32'h600);
    ex_wr_en = 1'b1; ex_wr_idx = 5'd3;
    #1;
    check("R9 stall raised", {31'b0, stall}, 32'd1);
    check("R9 no flush while stalled", {31'b0, flush}, 32'd0);
    cyc();
    check("R9 pc held", pc, 32'h100);
    #1;
    check("R9 stall once only", {31'b0, stall}, 32'd0);
    check("R9 resolved flush", {31'b0, flush}, 32'd1);
    cyc();
    check("R9 resolved target", pc, 32'h680);
    idle();
    cyc();
    drive(2'b01, 32'd0, 5'd3, 16'h0020, 32'h600);
    ex_wr_en = 1'b1; ex_wr_idx = 5'd4;
    #1;
    check("R9 other reg no stall", {31'b0, stall}, 32'd0);
    cyc();
    check("R9 other reg target", pc, 32'h680);
    idle();
  endtask

  task automatic t_delay_slot();
    do_reset();
    drive(2'b01, 32'd0, 5'd2, 16'h0010, 32'h200);
    #1;
    check("R8 no flush in delay mode", {31'b0, flush_ds}, 32'd0);
    cyc();
    check("R8 delay redirect", pc_ds, 32'h240);
    drive(2'b10, 32'd1, 5'd2, 16'h0004, 32'h104);
    #1;
    check("R8 slot branch no flush", {31'b0, flush_ds}, 32'd0);
    cyc();
    check("R8 slot branch evaluated", pc_ds, 32'h114);
    idle();
  endtask

  initial begin
    fork
      begin
        t_sequential();
        t_bz_taken_squash();
        t_bnz_and_not_taken();
        t_far_negative();
        t_non_branch();
        t_hazard();
        t_delay_slot();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule